// File: doc/BRIEF.md
# Return-Address Stack and Branch Sequencer

This block owns the program counter of a small byte-oriented interpreter core. Each accepted instruction first moves the counter forward by one instruction word (two bytes). Then, depending on its decoded class, the instruction keeps that advanced value, jumps to a 12-bit target, returns through a last-in-first-out stack of return addresses, or jumps to the target plus an 8-bit base register value. The base register is the one a program fills with a table offset before it dispatches.

The decoder in front of the block sends one instruction per clock at most, marked by a valid strobe, with a three-bit class code, the target field and the base register value. The block shows the current program counter. It also shows two sticky fault flags, one for a call made when the stack is full and one for a return made when it is empty. Fetch, memory and the other opcode groups are handled elsewhere.

Top module: `flow_ctrl_unit`

## Requirements
- R1: A synchronous reset sets the program counter to 0x200, empties the stack and clears both fault flags. All of this is visible in the cycle after reset is sampled.
- R2: In a cycle with `instr_valid` low, the program counter, the stack contents and the flags do not change.
- R3: A plain instruction (class 0) and an ignored legacy system call (class 4) only advance the program counter by 2, modulo 2^PC_W.
- R4: A call (class 1) with the stack not full pushes the advanced counter (old counter + 2) and loads the zero-extended target into the program counter.
- R5: A return (class 2) with the stack not empty loads the program counter from the most recent pushed entry and removes that entry. Calling 0xABC from 0x200 and then returning gives 0x202.
- R6: An indexed jump (class 3) loads the program counter with target + base, both zero-extended, with the sum wrapping modulo 2^PC_W.
- R7: Nested calls up to DEPTH deep return in reverse order of their calls.
- R8: A call made with DEPTH entries in use leaves the stack unchanged, only advances the program counter by 2, and sets `stk_ovf`. The flag stays set until reset.
- R9: A return made with the stack empty only advances the program counter by 2 and sets `stk_unf`. The flag stays set until reset.
- R10: Unassigned class codes 5, 6 and 7 behave as plain instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | An instruction is accepted this cycle |
| instr_kind | input | 3 | Class code: 0 plain, 1 call, 2 return, 3 indexed jump, 4 legacy system call, 5-7 plain |
| instr_target | input | TGT_W (12) | Address field of the instruction |
| base_val | input | REG_W (8) | Current value of the dispatch base register |
| pc | output | PC_W (16) | Current program counter |
| stk_ovf | output | 1 | Sticky: a call met a full stack |
| stk_unf | output | 1 | Sticky: a return met an empty stack |

## Verification
The bench builds the block with DEPTH = 4 and PC_W = 12, so that both limits can be hit with a short stimulus. After four nested calls the next call overflows the stack, and after four returns the next one underflows it. With a counter as narrow as the target field, an indexed jump from 0xFFF with base 0xFF wraps to 0x0FE, and a plain step from 0xFFE wraps to 0x000. With the default 16-bit counter neither wrap can occur. A bench-side model of the counter and the stack predicts every accepted or idle cycle, including the call 0x200 → 0xABC → return 0x202 sequence.

// File: rtl/flow_ctrl_pkg.sv
package flow_ctrl_pkg;

   typedef enum logic [2:0] {
      FC_PLAIN = 3'd0,
      FC_CALL  = 3'd1,
      FC_RET   = 3'd2,
      FC_JIDX  = 3'd3,
      FC_SYS   = 3'd4
   } fc_kind_e;

   localparam int unsigned FC_KIND_W = 3;

endpackage

// File: rtl/fc_ret_stack.sv
module fc_ret_stack #(
   parameter int unsigned DEPTH  = 16,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              push_req,
   input  logic              pop_req,
   input  logic [DATA_W-1:0] push_data,
   output logic [DATA_W-1:0] top_data,
   output logic              full,
   output logic              empty,
   output logic              ovf,
   output logic              unf
);

   localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned PTR_W = $clog2(DEPTH + 1);
   localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(DEPTH);

   initial begin
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("fc_ret_stack: DEPTH must be a power of two, at least 2");
      assert (DATA_W >= 1)
         else $error("fc_ret_stack: DATA_W must be positive");
   end

   logic [PTR_W-1:0]  ptr;
   logic [DATA_W-1:0] slot [DEPTH];
   logic [IDX_W-1:0]  wr_idx;
   logic [IDX_W-1:0]  rd_idx;
   logic              do_push;
   logic              do_pop;

   assign full    = (ptr == PTR_MAX);
   assign empty   = (ptr == '0);
   assign do_push = push_req && !full;
   assign do_pop  = pop_req && !empty;
   assign wr_idx  = ptr[IDX_W-1:0];
   assign rd_idx  = IDX_W'(ptr - PTR_W'(1));
   assign top_data = slot[rd_idx];

   // one register row per entry, each with its own write enable
   for (genvar g = 0; g < DEPTH; g++) begin : g_row
      always_ff @(posedge clk) begin
         if (do_push && (wr_idx == IDX_W'(g))) begin
            slot[g] <= push_data;
         end
      end
   end

   // pointer names the next free row: write-then-bump, drop-then-read
   always_ff @(posedge clk) begin
      if (rst) begin
         ptr <= '0;
      end else if (do_push) begin
         ptr <= ptr + PTR_W'(1);
      end else if (do_pop) begin
         ptr <= ptr - PTR_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ovf <= 1'b0;
         unf <= 1'b0;
      end else begin
         if (push_req && full) ovf <= 1'b1;
         if (pop_req && empty) unf <= 1'b1;
      end
   end

   // R8
   ptr_bound_chk: assert property (@(posedge clk) disable iff (rst)
      ptr <= PTR_MAX);

   // R8
   full_push_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (push_req && full) |=> full);

   // R9
   empty_pop_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (pop_req && empty) |=> empty);

   // R8
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      ovf |=> ovf);

   // R9
   unf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      unf |=> unf);

   // R4
   req_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(push_req && pop_req));

endmodule

// File: rtl/fc_pc_next.sv
module fc_pc_next
   import flow_ctrl_pkg::*;
#(
   parameter int unsigned PC_W  = 16,
   parameter int unsigned TGT_W = 12,
   parameter int unsigned REG_W = 8,
   parameter int unsigned STEP  = 2
) (
   input  logic                 valid,
   input  logic [FC_KIND_W-1:0] kind,
   input  logic [PC_W-1:0]      pc_cur,
   input  logic [TGT_W-1:0]     target,
   input  logic [REG_W-1:0]     base,
   input  logic [PC_W-1:0]      stack_top,
   input  logic                 stack_full,
   input  logic                 stack_empty,
   output logic [PC_W-1:0]      pc_step,
   output logic [PC_W-1:0]      pc_nxt,
   output logic                 push_req,
   output logic                 pop_req
);

   logic [PC_W-1:0] tgt_ext;
   logic [PC_W-1:0] base_ext;

   // the counter may be wider or narrower than the address field
   if (TGT_W < PC_W) begin : g_tgt_zext
      assign tgt_ext = {{(PC_W - TGT_W){1'b0}}, target};
   end else begin : g_tgt_trunc
      assign tgt_ext = target[PC_W-1:0];
   end

   if (REG_W < PC_W) begin : g_base_zext
      assign base_ext = {{(PC_W - REG_W){1'b0}}, base};
   end else begin : g_base_trunc
      assign base_ext = base[PC_W-1:0];
   end

   assign pc_step  = pc_cur + PC_W'(STEP);
   assign push_req = valid && (kind == FC_CALL);
   assign pop_req  = valid && (kind == FC_RET);

   always_comb begin
      pc_nxt = pc_cur;
      if (valid) begin
         unique case (kind)
            FC_CALL: pc_nxt = stack_full  ? pc_step : tgt_ext;
            FC_RET:  pc_nxt = stack_empty ? pc_step : stack_top;
            FC_JIDX: pc_nxt = tgt_ext + base_ext;
            default: pc_nxt = pc_step;
         endcase
      end
   end

endmodule

// File: rtl/flow_ctrl_unit.sv
module flow_ctrl_unit
   import flow_ctrl_pkg::*;
#(
   parameter int unsigned DEPTH    = 16,
   parameter int unsigned PC_W     = 16,
   parameter int unsigned TGT_W    = 12,
   parameter int unsigned REG_W    = 8,
   parameter int unsigned STEP     = 2,
   parameter int unsigned RESET_PC = 32'h200
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 instr_valid,
   input  logic [FC_KIND_W-1:0] instr_kind,
   input  logic [TGT_W-1:0]     instr_target,
   input  logic [REG_W-1:0]     base_val,
   output logic [PC_W-1:0]      pc,
   output logic                 stk_ovf,
   output logic                 stk_unf
);

   localparam logic [PC_W-1:0] PC_INIT = PC_W'(RESET_PC);

   initial begin
      assert (PC_W >= 8 && PC_W <= 32)
         else $error("flow_ctrl_unit: PC_W out of range");
      assert (TGT_W >= 1 && REG_W >= 1)
         else $error("flow_ctrl_unit: field widths must be positive");
      assert (RESET_PC < (64'd1 << PC_W))
         else $error("flow_ctrl_unit: RESET_PC does not fit PC_W");
   end

   logic [PC_W-1:0] pc_step;
   logic [PC_W-1:0] pc_nxt;
   logic [PC_W-1:0] top_data;
   logic            push_req;
   logic            pop_req;
   logic            full;
   logic            empty;

   fc_pc_next #(
      .PC_W  (PC_W),
      .TGT_W (TGT_W),
      .REG_W (REG_W),
      .STEP  (STEP)
   ) u_next (
      .valid       (instr_valid),
      .kind        (instr_kind),
      .pc_cur      (pc),
      .target      (instr_target),
      .base        (base_val),
      .stack_top   (top_data),
      .stack_full  (full),
      .stack_empty (empty),
      .pc_step     (pc_step),
      .pc_nxt      (pc_nxt),
      .push_req    (push_req),
      .pop_req     (pop_req)
   );

   fc_ret_stack #(
      .DEPTH  (DEPTH),
      .DATA_W (PC_W)
   ) u_stack (
      .clk       (clk),
      .rst       (rst),
      .push_req  (push_req),
      .pop_req   (pop_req),
      .push_data (pc_step),
      .top_data  (top_data),
      .full      (full),
      .empty     (empty),
      .ovf       (stk_ovf),
      .unf       (stk_unf)
   );

   always_ff @(posedge clk) begin
      if (rst) pc <= PC_INIT;
      else     pc <= pc_nxt;
   end

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !instr_valid |=> (pc == $past(pc)));

   // R3
   plain_step_chk: assert property (@(posedge clk) disable iff (rst)
      (instr_valid && (instr_kind == FC_PLAIN || instr_kind == FC_SYS))
      |=> (pc == $past(pc) + PC_W'(STEP)));

   // R4
   call_target_chk: assert property (@(posedge clk) disable iff (rst)
      (instr_valid && instr_kind == FC_CALL && !full)
      |=> (pc == PC_W'($past(instr_target))));

   // R8
   call_full_step_chk: assert property (@(posedge clk) disable iff (rst)
      (instr_valid && instr_kind == FC_CALL && full)
      |=> (stk_ovf && pc == $past(pc) + PC_W'(STEP)));

   // R9
   ret_empty_step_chk: assert property (@(posedge clk) disable iff (rst)
      (instr_valid && instr_kind == FC_RET && empty)
      |=> (stk_unf && pc == $past(pc) + PC_W'(STEP)));

endmodule

// File: tb/flow_ctrl_unit_test.sv
module flow_ctrl_unit_test;

   localparam int unsigned DEPTH = 4;
   localparam int unsigned PC_W  = 12;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic            instr_valid = 1'b0;
   logic [2:0]      instr_kind = 3'd0;
   logic [11:0]     instr_target = '0;
   logic [7:0]      base_val = '0;
   logic [PC_W-1:0] pc;
   logic            stk_ovf;
   logic            stk_unf;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   flow_ctrl_unit #(.DEPTH(DEPTH), .PC_W(PC_W)) uut (
      .clk (clk), .rst (rst), .instr_valid (instr_valid),
      .instr_kind (instr_kind), .instr_target (instr_target),
      .base_val (base_val), .pc (pc), .stk_ovf (stk_ovf), .stk_unf (stk_unf)
   );

   // reference model
   logic [PC_W-1:0] m_pc;
   logic [PC_W-1:0] m_stk [DEPTH];
   int              m_sp;
   logic            m_ovf;
   logic            m_unf;

   // scoreboard queues
   logic [PC_W-1:0] q_pc [$];
   logic [1:0]      q_fl [$];
   string           q_tag [$];

   task automatic compare(input string tag, input logic [PC_W-1:0] epc,
                          input logic [1:0] efl);
      checks++;
      if (pc !== epc || {stk_ovf, stk_unf} !== efl) begin
         fails++;
         $display("FAIL %s: pc=%h ovf/unf=%b expected pc=%h ovf/unf=%b",
                  tag, pc, {stk_ovf, stk_unf}, epc, efl);
      end
   endtask

   task automatic model_reset();
      m_pc = 12'h200; m_sp = 0; m_ovf = 1'b0; m_unf = 1'b0;
   endtask

   task automatic issue(input bit v, input logic [2:0] k, input logic [11:0] t,
                        input logic [7:0] b, input string tag);
      logic [PC_W-1:0] step;
      @(negedge clk);
      instr_valid = v; instr_kind = k; instr_target = t; base_val = b;
      step = m_pc + 12'd2;
      if (v) begin
         case (k)
            3'd1: if (m_sp == DEPTH) begin m_ovf = 1'b1; m_pc = step; end
                  else begin m_stk[m_sp] = step; m_sp++; m_pc = t; end
            3'd2: if (m_sp == 0) begin m_unf = 1'b1; m_pc = step; end
                  else begin m_sp--; m_pc = m_stk[m_sp]; end
            3'd3: m_pc = t + {4'd0, b};
            default: m_pc = step;
         endcase
      end
      q_pc.push_back(m_pc);
      q_fl.push_back({m_ovf, m_unf});
      q_tag.push_back(tag);
   endtask

   // monitor: one expectation per cycle in which the driver queued one
   always @(posedge clk) begin
      #1;
      if (q_pc.size() > 0) begin
         compare(q_tag.pop_front(), q_pc.pop_front(), q_fl.pop_front());
      end
   end

   task automatic do_reset(input string tag);
      @(negedge clk);
      rst = 1'b1; instr_valid = 1'b0;
      @(negedge clk);
      rst = 1'b0;
      model_reset();
      compare(tag, 12'h200, 2'b00);
   endtask

   initial begin
      model_reset();
      repeat (2) @(negedge clk);
      rst = 1'b0;
      compare("R1 reset state", 12'h200, 2'b00);

      // R5: call from 0x200 to 0xABC, return lands on 0x202
      issue(1, 3'd1, 12'hABC, 8'h00, "R4 call");
      issue(1, 3'd2, 12'h000, 8'h00, "R5 return");
      // R2: idle cycles hold everything
      issue(0, 3'd1, 12'h123, 8'h00, "R2 idle");
      issue(0, 3'd3, 12'h456, 8'h11, "R2 idle");
      // R3 / R10
      issue(1, 3'd0, 12'hFFF, 8'hFF, "R3 plain");
      issue(1, 3'd4, 12'h0E0, 8'h00, "R3 sys ignored");
      issue(1, 3'd5, 12'h777, 8'h00, "R10 code5");
      issue(1, 3'd6, 12'h777, 8'h00, "R10 code6");
      issue(1, 3'd7, 12'h777, 8'h00, "R10 code7");
      // R6
      issue(1, 3'd3, 12'h100, 8'h10, "R6 jidx");
      issue(1, 3'd3, 12'hFFF, 8'hFF, "R6 jidx wrap");
      issue(1, 3'd3, 12'hFFE, 8'h00, "R6 jidx plain");
      issue(1, 3'd0, 12'h000, 8'h00, "R3 step wrap");
      // R7 / R8 / R9: fill, overflow, unwind, underflow
      issue(1, 3'd1, 12'h100, 8'h00, "R7 call1");
      issue(1, 3'd1, 12'h230, 8'h00, "R7 call2");
      issue(1, 3'd1, 12'h340, 8'h00, "R7 call3");
      issue(1, 3'd1, 12'h450, 8'h00, "R7 call4");
      issue(1, 3'd1, 12'h560, 8'h00, "R8 call full");
      issue(1, 3'd0, 12'h000, 8'h00, "R8 sticky");
      for (int i = 0; i < DEPTH; i++) issue(1, 3'd2, 12'h000, 8'h00, "R7 unwind");
      issue(1, 3'd2, 12'h000, 8'h00, "R9 ret empty");
      issue(0, 3'd0, 12'h000, 8'h00, "R9 sticky");
      issue(1, 3'd1, 12'h0C8, 8'h00, "R4 call after faults");
      wait (q_pc.size() == 0);
      @(negedge clk);
      do_reset("R1 reset clears flags");
      issue(1, 3'd2, 12'h000, 8'h00, "R9 empty after reset");
      wait (q_pc.size() == 0);
      @(negedge clk);
      if (!finished) begin
         finished = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      #400000;
      if (!finished) begin
         finished = 1'b1;
         checks++; fails++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

endmodule